// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Manager

This block keeps a DDR SDRAM refreshed without help from the rest of the memory controller. A free-running interval timer counts clock cycles. Each time it expires, one refresh is added to a count of owed refreshes. While refreshes are owed, the block asks the command scheduler to close every bank. Once the scheduler grants, the block waits out the precharge period. It then drives an auto-refresh command onto the command pins and holds off all scheduler traffic for the refresh cycle time. The scheduler may defer a request while traffic is heavy. When the owed count reaches its ceiling, the block raises an urgent flag so that the refresh goes ahead of any traffic.

The same grant path also takes the device into self-refresh. A level request input asks for self-refresh. After the precharge wait, the block issues the refresh encoding with the clock enable low and keeps the clock enable low for as long as the request stays high. The interval timer holds at zero during this time. When the request drops, the clock enable returns high and the timer starts again from zero. Two stall outputs then keep non-read commands and read commands back for separate, longer exit windows.

All delays are given in clock cycles through parameters. With the defaults at 250 MHz they are a 7.8 µs interval, a 75 ns refresh cycle, a 20 ns precharge period, a 75 ns non-read exit delay and a 200-clock read exit delay.

Top module: `dram_refresh_mgr`

## Requirements
- R1: After reset, the owed count is 0, clock enable is high, no request, stall or urgent flag is raised, and the command pins show deselect (all four active-low lines high, command valid low).
- R2: Outside self-refresh, the owed count rises by one every REFI_CYC cycles, with the first rise REFI_CYC cycles after reset. The precharge request is high while the sequencer is idle and either the owed count is non-zero or the self-refresh request is high.
- R3: The urgent flag is high exactly when the owed count equals DEBT_MAX (8 by default).
- R4: The owed count never exceeds DEBT_MAX. A timer expiry at the ceiling is dropped.
- R5: A grant sampled while the request is high, with self-refresh not requested, is followed RP_CYC cycles later by a one-cycle auto-refresh command. The encoding is cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1. The owed count drops by one on the cycle after the command. Stall is high from the cycle after the grant.
- R6: Stall stays high from the auto-refresh command cycle through RFC_CYC-1 further cycles, so the next command can come no earlier than RFC_CYC cycles after the refresh.
- R7: A grant sampled while the precharge request is low changes nothing: no command is issued and stall does not change.
- R8: A grant sampled while the self-refresh request is high leads, RP_CYC cycles later, to the refresh encoding with cke=0. The owed count is then cleared, and cke stays low while the request is held.
- R9: The interval timer is held at zero during self-refresh. The first owed refresh after exit appears REFI_CYC cycles after cke returns high.
- R10: cke returns high on the cycle after the self-refresh request is sampled low. From that cycle, stall stays high for XSNR_CYC cycles and the read stall stays high for XSRD_CYC cycles. A stall always implies a read stall.
- R11: When command valid is low, the command pins show deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sr_req_i | input | 1 | Level request to enter and stay in self-refresh |
| pre_gnt_i | input | 1 | Scheduler grant: all banks closed by a precharge-all |
| pre_req_o | output | 1 | Request to the scheduler to close all banks |
| urgent_o | output | 1 | Owed count at its ceiling, refresh must pre-empt traffic |
| pend_o | output | $clog2(DEBT_MAX+1) | Number of owed refreshes |
| stall_o | output | 1 | Scheduler must issue no command |
| rd_stall_o | output | 1 | Scheduler must issue no read |
| cmd_v_o | output | 1 | Block is driving a command this cycle |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
The properties assume that the scheduler asserts the grant only while the request is high, and only after its precharge-all has been issued. They also assume that the scheduler keeps the banks closed until stall falls. The stall-related properties further assume that RFC_CYC is at least 2 and that XSRD_CYC is at least XSNR_CYC. The stimulus drives every input at the falling clock edge, pulses the grant for a single cycle, and times each grant away from timer expiries so that the expected owed count is exact. One grant is sent on purpose while no request is raised, to show that it is ignored.

// File: rtl/drm_pkg.sv
package drm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_AREF,
        ST_RFC,
        ST_SRE,
        ST_SELF,
        ST_XS
    } seq_st_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam ddr_cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
    parameter int REFI_CYC = 1950
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic freeze_i,
    output logic tick_o
);
    localparam int TW = $clog2(REFI_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(REFI_CYC - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        tick_o = 1'b0;
        if (freeze_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == LAST) begin
            tmr_d.cnt = '0;
            tick_o    = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end
endmodule

// File: rtl/debt_ctr.sv
module debt_ctr #(
    parameter int DEBT_MAX = 8,
    localparam int PW = $clog2(DEBT_MAX + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          dec_i,
    input  logic          clr_i,
    output logic [PW-1:0] pend_o,
    output logic          full_o
);
    localparam logic [PW-1:0] TOP = PW'(DEBT_MAX);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } debt_t;

    debt_t debt_d, debt_q;

    always_comb begin
        debt_d = debt_q;
        if (clr_i) begin
            debt_d.cnt = '0;
        end else begin
            unique case ({tick_i, dec_i})
                2'b10: if (debt_q.cnt != TOP) debt_d.cnt = debt_q.cnt + 1'b1;
                2'b01: if (debt_q.cnt != '0)  debt_d.cnt = debt_q.cnt - 1'b1;
                default: debt_d.cnt = debt_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) debt_q <= '0;
        else         debt_q <= debt_d;
    end

    assign pend_o = debt_q.cnt;
    assign full_o = (debt_q.cnt == TOP);
endmodule

// File: rtl/ref_seq.sv
module ref_seq
    import drm_pkg::*;
#(
    parameter int RP_CYC   = 5,
    parameter int RFC_CYC  = 19,
    parameter int XSNR_CYC = 19,
    parameter int XSRD_CYC = 200
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     pend_nz_i,
    input  logic     sr_req_i,
    input  logic     gnt_i,
    output logic     pre_req_o,
    output logic     stall_o,
    output logic     rd_stall_o,
    output logic     freeze_o,
    output logic     issue_ref_o,
    output logic     issue_sre_o,
    output logic     cke_o,
    output ddr_cmd_t cmd_o
);
    localparam int M1   = (RP_CYC > RFC_CYC) ? RP_CYC : RFC_CYC;
    localparam int MAXC = (M1 > XSRD_CYC) ? M1 : XSRD_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RP_END   = CW'(RP_CYC - 1);
    localparam logic [CW-1:0] RFC_END  = CW'(RFC_CYC - 2);
    localparam logic [CW-1:0] XSNR_LIM = CW'(XSNR_CYC);
    localparam logic [CW-1:0] XSRD_END = CW'(XSRD_CYC - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic          to_sr;
    } seq_t;

    seq_t seq_d, seq_q;

    assign pre_req_o = (seq_q.st == ST_IDLE) && (pend_nz_i || sr_req_i);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (pre_req_o && gnt_i) begin
                    seq_d.st    = ST_PRE;
                    seq_d.cnt   = '0;
                    seq_d.to_sr = sr_req_i;
                end
            end
            ST_PRE: begin
                if (seq_q.cnt == RP_END) begin
                    seq_d.st  = seq_q.to_sr ? ST_SRE : ST_AREF;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_AREF: begin
                seq_d.st  = ST_RFC;
                seq_d.cnt = '0;
            end
            ST_RFC: begin
                if (seq_q.cnt == RFC_END) seq_d.st  = ST_IDLE;
                else                      seq_d.cnt = seq_q.cnt + 1'b1;
            end
            ST_SRE: begin
                seq_d.st = ST_SELF;
            end
            ST_SELF: begin
                if (!sr_req_i) begin
                    seq_d.st  = ST_XS;
                    seq_d.cnt = '0;
                end
            end
            ST_XS: begin
                if (seq_q.cnt == XSRD_END) seq_d.st  = ST_IDLE;
                else                       seq_d.cnt = seq_q.cnt + 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{st: ST_IDLE, cnt: '0, to_sr: 1'b0};
        else         seq_q <= seq_d;
    end

    assign issue_ref_o = (seq_q.st == ST_AREF);
    assign issue_sre_o = (seq_q.st == ST_SRE);
    assign freeze_o    = (seq_q.st == ST_SRE) || (seq_q.st == ST_SELF);
    assign cke_o       = !freeze_o;
    assign cmd_o       = (issue_ref_o || issue_sre_o) ? CMD_REF : CMD_DESEL;
    assign rd_stall_o  = (seq_q.st != ST_IDLE);
    assign stall_o     = rd_stall_o && !((seq_q.st == ST_XS) && (seq_q.cnt >= XSNR_LIM));
endmodule

// File: rtl/dram_refresh_mgr.sv
module dram_refresh_mgr
    import drm_pkg::*;
#(
    parameter int REFI_CYC = 1950,
    parameter int RFC_CYC  = 19,
    parameter int RP_CYC   = 5,
    parameter int XSNR_CYC = 19,
    parameter int XSRD_CYC = 200,
    parameter int DEBT_MAX = 8
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          sr_req_i,
    input  logic                          pre_gnt_i,
    output logic                          pre_req_o,
    output logic                          urgent_o,
    output logic [$clog2(DEBT_MAX+1)-1:0] pend_o,
    output logic                          stall_o,
    output logic                          rd_stall_o,
    output logic                          cmd_v_o,
    output logic                          cke_o,
    output logic                          cs_n_o,
    output logic                          ras_n_o,
    output logic                          cas_n_o,
    output logic                          we_n_o
);
    logic     tick;
    logic     freeze;
    logic     issue_ref;
    logic     issue_sre;
    ddr_cmd_t cmd;

    refi_timer #(.REFI_CYC(REFI_CYC)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .freeze_i (freeze),
        .tick_o   (tick)
    );

    debt_ctr #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .dec_i  (issue_ref),
        .clr_i  (issue_sre),
        .pend_o (pend_o),
        .full_o (urgent_o)
    );

    ref_seq #(
        .RP_CYC   (RP_CYC),
        .RFC_CYC  (RFC_CYC),
        .XSNR_CYC (XSNR_CYC),
        .XSRD_CYC (XSRD_CYC)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pend_nz_i   (pend_o != '0),
        .sr_req_i    (sr_req_i),
        .gnt_i       (pre_gnt_i),
        .pre_req_o   (pre_req_o),
        .stall_o     (stall_o),
        .rd_stall_o  (rd_stall_o),
        .freeze_o    (freeze),
        .issue_ref_o (issue_ref),
        .issue_sre_o (issue_sre),
        .cke_o       (cke_o),
        .cmd_o       (cmd)
    );

    assign cmd_v_o = issue_ref || issue_sre;
    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
endmodule

// File: rtl/drm_chk.sv
module drm_chk #(
    parameter int DEBT_MAX = 8
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          pre_req_o,
    input logic                          urgent_o,
    input logic [$clog2(DEBT_MAX+1)-1:0] pend_o,
    input logic                          stall_o,
    input logic                          rd_stall_o,
    input logic                          cmd_v_o,
    input logic                          cke_o,
    input logic                          cs_n_o
);
    // R4
    pend_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_o <= ($clog2(DEBT_MAX+1))'(DEBT_MAX));

    // R3
    urgent_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        urgent_o |-> pre_req_o || stall_o);

    // R2
    req_when_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_req_o |-> !stall_o && !rd_stall_o);

    // R5
    cmd_after_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_v_o |-> $past(stall_o) && !pre_req_o);

    // R6
    rfc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_v_o && cke_o |=> stall_o && !cmd_v_o);

    // R8
    sre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_v_o && !cke_o |=> !cke_o && pend_o == '0);

    // R10
    exit_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cke_o) |-> stall_o && rd_stall_o);

    // R10
    stall_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> rd_stall_o);

    // R11
    desel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_v_o |-> cs_n_o);
endmodule

bind dram_refresh_mgr drm_chk #(.DEBT_MAX(DEBT_MAX)) u_drm_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pre_req_o  (pre_req_o),
    .urgent_o   (urgent_o),
    .pend_o     (pend_o),
    .stall_o    (stall_o),
    .rd_stall_o (rd_stall_o),
    .cmd_v_o    (cmd_v_o),
    .cke_o      (cke_o),
    .cs_n_o     (cs_n_o)
);

// File: tb/tb_dram_refresh_mgr.sv
`timescale 1ns/1ps
module tb_dram_refresh_mgr;
    localparam int REFI = 40;
    localparam int RFC  = 6;
    localparam int RP   = 3;
    localparam int XSNR = 5;
    localparam int XSRD = 12;
    localparam int DMAX = 8;
    localparam int PW   = $clog2(DMAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_req = 1'b0;
    logic gnt = 1'b0;
    logic pre_req, urgent, stall, rd_stall, cmd_v, cke, cs_n, ras_n, cas_n, we_n;
    logic [PW-1:0] pend;

    always #2 clk = ~clk;

    dram_refresh_mgr #(
        .REFI_CYC(REFI), .RFC_CYC(RFC), .RP_CYC(RP),
        .XSNR_CYC(XSNR), .XSRD_CYC(XSRD), .DEBT_MAX(DMAX)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .sr_req_i(sr_req), .pre_gnt_i(gnt),
        .pre_req_o(pre_req), .urgent_o(urgent), .pend_o(pend),
        .stall_o(stall), .rd_stall_o(rd_stall), .cmd_v_o(cmd_v),
        .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct { int self_ref; int at; } exp_t;
    exp_t q[$];

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic expect_cmd(int self_ref, int at);
        q.push_back('{self_ref: self_ref, at: at});
    endtask

    task automatic go_to(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic grant_pulse();
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
    endtask

    // monitor: pops expected commands and compares them with what appears on the pins
    always @(negedge clk) begin
        if (rst_n && cmd_v) begin
            if (q.size() == 0) begin
                chk("R7 unexpected command", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R5 command cycle", cyc, e.at);
                chk("R5 cs_n", int'(cs_n), 0);
                chk("R5 ras_n", int'(ras_n), 0);
                chk("R5 cas_n", int'(cas_n), 0);
                chk("R5 we_n", int'(we_n), 1);
                if (e.self_ref != 0) chk("R8 cke low on entry", int'(cke), 0);
                else                 chk("R5 cke high on refresh", int'(cke), 1);
            end
        end
    end

    initial begin
        #80000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pend", int'(pend), 0);
        chk("R1 pre_req", int'(pre_req), 0);
        chk("R1 cke", int'(cke), 1);
        chk("R1 stall", int'(stall), 0);
        chk("R1 rd_stall", int'(rd_stall), 0);
        chk("R1 urgent", int'(urgent), 0);
        chk("R1 cmd_v", int'(cmd_v), 0);
        chk("R11 deselect", int'({cs_n, ras_n, cas_n, we_n}), 15);

        go_to(REFI - 1);
        chk("R2 pend before first expiry", int'(pend), 0);
        chk("R2 no request yet", int'(pre_req), 0);
        go_to(REFI);
        chk("R2 pend after first expiry", int'(pend), 1);
        chk("R2 request raised", int'(pre_req), 1);
        chk("R3 urgent low", int'(urgent), 0);

        go_to(8 * REFI - 1);
        chk("R3 pend seven", int'(pend), 7);
        chk("R3 urgent still low", int'(urgent), 0);
        go_to(8 * REFI);
        chk("R3 pend at ceiling", int'(pend), 8);
        chk("R3 urgent high", int'(urgent), 1);
        go_to(365);
        chk("R4 saturated", int'(pend), 8);

        // auto-refresh after grant at 365
        expect_cmd(0, 365 + RP + 1);
        grant_pulse();
        chk("R5 stall after grant", int'(stall), 1);
        chk("R5 request dropped", int'(pre_req), 0);
        go_to(371);
        chk("R5 pend decremented", int'(pend), 7);
        chk("R3 urgent cleared", int'(urgent), 0);
        go_to(369 + RFC - 1);
        chk("R6 stall last rfc cycle", int'(stall), 1);
        go_to(369 + RFC);
        chk("R6 stall released", int'(stall), 0);

        go_to(380);
        expect_cmd(0, 380 + RP + 1);
        grant_pulse();
        go_to(386);
        chk("R5 second decrement", int'(pend), 6);
        // R7 grant while the request is low (inside refresh cycle time)
        grant_pulse();
        go_to(391);
        chk("R7 stall unchanged", int'(stall), 0);
        chk("R7 pend unchanged", int'(pend), 6);

        // self-refresh entry at 405 (pend 7 after tick at 400)
        go_to(405);
        sr_req = 1'b1;
        expect_cmd(1, 405 + RP + 1);
        grant_pulse();
        go_to(410);
        chk("R8 cke low", int'(cke), 0);
        chk("R8 pend cleared", int'(pend), 0);
        chk("R8 stall", int'(stall), 1);
        go_to(500);
        chk("R9 pend frozen", int'(pend), 0);
        chk("R8 cke held low", int'(cke), 0);
        sr_req = 1'b0;
        @(negedge clk);
        chk("R10 cke high after exit", int'(cke), 1);
        chk("R10 stall on exit", int'(stall), 1);
        go_to(501 + XSNR - 1);
        chk("R10 stall last cycle", int'(stall), 1);
        go_to(501 + XSNR);
        chk("R10 non-read allowed", int'(stall), 0);
        chk("R10 read still held", int'(rd_stall), 1);
        go_to(501 + XSRD - 1);
        chk("R10 read held last cycle", int'(rd_stall), 1);
        go_to(501 + XSRD);
        chk("R10 read allowed", int'(rd_stall), 0);

        // R7 idle grant with nothing owed
        go_to(520);
        chk("R7 no request", int'(pre_req), 0);
        grant_pulse();
        @(negedge clk);
        chk("R7 idle grant no stall", int'(stall), 0);
        chk("R7 idle grant no read stall", int'(rd_stall), 0);

        go_to(501 + REFI - 1);
        chk("R9 timer restart before", int'(pend), 0);
        go_to(501 + REFI);
        chk("R9 timer restart after", int'(pend), 1);
        chk("R2 request after restart", int'(pre_req), 1);

        go_to(560);
        chk("R5 all commands seen", q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule